// File: doc/BRIEF.md
# Destination Address Filter with Loadable CAM

This block decides, for each incoming frame, whether its 48-bit destination address is wanted, and labels the frame as plain, multicast or broadcast. The first address byte sits in bits 7:0 of `dst_addr_i`, and bit 0 of that byte is the group (multicast) bit. Three mode inputs are checked in a fixed order ahead of a 16-entry content-addressable memory: promiscuous, accept-all-multicast and broadcast. Only CAM entries whose bit is set in a 16-bit enable mask take part in the compare.

A sequencer fills the CAM from a stream of 16-bit words on a valid/ready interface. Software starts it with an entry count. For each entry the stream carries one word that is thrown away, then three address words. The enable mask follows the last entry. While the block is held in reset mode, software can read the entries back through three 16-bit port registers selected by an entry pointer.

A filter request is a one-cycle strobe. The verdict comes back two cycles later with a one-cycle valid pulse.

Top module: `cam_addr_filter`

## Requirements
- R1: With `prom_i` set, a frame whose group bit is 0 is accepted with type 00 (plain), ahead of every other check. A frame with the group bit set is not accepted by this mode.
- R2: With `allmc_i` set, a frame whose group bit is 1 is accepted with type 01 (multicast). This holds for the all-ones address too, even when `bcast_i` is set.
- R3: With `bcast_i` set and R1 and R2 not applying, the all-ones address is accepted with type 10 (broadcast). Without any mode set, it is rejected unless the CAM matches it.
- R4: When no mode applies, a frame is accepted with type 00 if its address equals an entry whose enable-mask bit is set. Otherwise it is rejected, and a rejected frame reports type 00.
- R5: `load_start_i` starts a load that takes entries at indices counting up from 0. `load_count_i` (5 bits) gives the number of entries and counts down once per entry. Each entry uses four words: one discarded word, then words giving address bytes {1,0}, {3,2} and {5,4}, with the low byte of each word being the lower-numbered address byte.
- R6: After the last entry, one more word becomes the enable mask. A count of 0 loads only that mask word. Once the mask word is taken, `load_busy_o` falls and `load_done_o` rises. `load_done_o` stays set until the next load start, which clears it. `word_ready_o` is high only while a load is in progress.
- R7: `port_data_o` returns entry `port_ptr_i`. Select 0 gives address bytes {1,0}, select 1 gives {3,2} and select 2 gives {5,4}, with the higher-numbered byte in bits 15:8. Select 3 returns 0, and every select returns 0 while `reset_mode_i` is low.
- R8: `valid_o` is high for exactly one cycle, two clock edges after each `start_i` strobe. Back-to-back strobes give back-to-back results.
- R9: Reset clears the enable mask and every entry, so no CAM compare succeeds until a load completes. The mask changes only when a load takes its mask word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_mode_i | input | 1 | Reset mode held by software; enables CAM readback |
| prom_i | input | 1 | Promiscuous mode |
| allmc_i | input | 1 | Accept-all-multicast mode |
| bcast_i | input | 1 | Broadcast accept mode |
| dst_addr_i | input | 48 | Destination address, first byte in bits 7:0 |
| start_i | input | 1 | One-cycle filter request |
| valid_o | output | 1 | Result valid pulse |
| accept_o | output | 1 | Frame accepted |
| type_o | output | 2 | 00 plain, 01 multicast, 10 broadcast |
| load_start_i | input | 1 | Start a CAM load |
| load_count_i | input | 5 | Number of entries to load |
| word_valid_i | input | 1 | Load word valid |
| word_data_i | input | 16 | Load word |
| word_ready_o | output | 1 | Load word accepted when valid |
| load_busy_o | output | 1 | Load in progress |
| load_done_o | output | 1 | Load finished, sticky until next start |
| port_sel_i | input | 2 | Port register select |
| port_ptr_i | input | 4 | Entry pointer for readback |
| port_data_o | output | 16 | Readback data |

## Verification
The filter is tried on several kinds of address. Unicast addresses held in enabled entries, in disabled entries, and in no entry show whether the mask gates the compare. Multicast and all-ones addresses under each combination of modes show whether the priority order is right, in particular accept-all-multicast winning over broadcast. A filter request before any load shows that the reset clears the mask. A load with count 0 shows that the mask can change while the entries keep their values. Readback of each port select at loaded and unloaded pointers, inside and outside reset mode, shows the byte order and the entry indexing.

// File: rtl/cam_filt_pkg.sv
`timescale 1ns/1ps
package cam_filt_pkg;
  typedef enum logic [1:0] {
    FT_PLAIN = 2'b00,
    FT_MCAST = 2'b01,
    FT_BCAST = 2'b10
  } frame_type_e;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_SKIP,
    LD_W1,
    LD_W2,
    LD_W3,
    LD_MASK
  } ld_state_e;
endpackage

// File: rtl/cam_load_seq.sv
`timescale 1ns/1ps
module cam_load_seq
  import cam_filt_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned CNT_W     = 5,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned ENT_W    = 3 * WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 word_valid_i,
  input  logic [WORD_W-1:0]    word_data_i,
  output logic                 word_ready_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 ent_we_o,
  output logic [IDX_W-1:0]     ent_idx_o,
  output logic [ENT_W-1:0]     ent_data_o,
  output logic                 mask_we_o,
  output logic [N_ENTRIES-1:0] mask_data_o
);
  ld_state_e           state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [IDX_W-1:0]    idx_q;
  logic [2*WORD_W-1:0] hold_q;
  logic                done_q;
  logic                acc;

  assign busy_o       = (state_q != LD_IDLE);
  assign word_ready_o = busy_o;
  assign acc          = word_valid_i && word_ready_o;
  assign done_o       = done_q;

  // third address word completes the entry: {w3, w2, w1}, byte 0 in w1[7:0]
  assign ent_we_o    = acc && (state_q == LD_W3);
  assign ent_idx_o   = idx_q;
  assign ent_data_o  = {word_data_i, hold_q};
  assign mask_we_o   = acc && (state_q == LD_MASK);
  assign mask_data_o = N_ENTRIES'(word_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        LD_IDLE: if (start_i) begin
          cnt_q   <= count_i;
          idx_q   <= '0;
          done_q  <= 1'b0;
          state_q <= (count_i == '0) ? LD_MASK : LD_SKIP;
        end
        LD_SKIP: if (acc) state_q <= LD_W1;
        LD_W1: if (acc) begin
          hold_q[WORD_W-1:0] <= word_data_i;
          state_q            <= LD_W2;
        end
        LD_W2: if (acc) begin
          hold_q[2*WORD_W-1:WORD_W] <= word_data_i;
          state_q                   <= LD_W3;
        end
        LD_W3: if (acc) begin
          cnt_q   <= cnt_q - CNT_W'(1);
          idx_q   <= idx_q + IDX_W'(1);
          state_q <= (cnt_q == CNT_W'(1)) ? LD_MASK : LD_SKIP;
        end
        LD_MASK: if (acc) begin
          done_q  <= 1'b1;
          state_q <= LD_IDLE;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  AST_ENTRY_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_we_o |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_DONE_ON_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_o |=> (done_o && !busy_o)); // R6
  AST_START_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!done_o && busy_o)); // R6
endmodule

// File: rtl/cam_store.sv
`timescale 1ns/1ps
module cam_store #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned WORD_W    = 16,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned N_PORTS  = 3,
  localparam int unsigned ENT_W    = N_PORTS * WORD_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             ent_we_i,
  input  logic [IDX_W-1:0]                 ent_idx_i,
  input  logic [ENT_W-1:0]                 ent_data_i,
  input  logic                             mask_we_i,
  input  logic [N_ENTRIES-1:0]             mask_data_i,
  output logic [N_ENTRIES-1:0][ENT_W-1:0]  entries_o,
  output logic [N_ENTRIES-1:0]             mask_o,
  input  logic                             rd_en_i,
  input  logic [IDX_W-1:0]                 rd_ptr_i,
  input  logic [1:0]                       rd_sel_i,
  output logic [WORD_W-1:0]                rd_data_o
);
  logic [N_ENTRIES-1:0] mask_q;
  logic [ENT_W-1:0]     rd_ent;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q <= '0;
      else if (ent_we_i && ent_idx_i == IDX_W'(e))    ent_q <= ent_data_i;
    end
    assign entries_o[e] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_data_i;
  end
  assign mask_o = mask_q;

  assign rd_ent = entries_o[rd_ptr_i];

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (rd_en_i && rd_sel_i == 2'(p)) rd_data_o = rd_ent[p*WORD_W +: WORD_W];
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_o)); // R9
  AST_ENTRY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_we_i |=> (entries_o[$past(ent_idx_i)] == $past(ent_data_i))); // R5
endmodule

// File: rtl/cam_match.sv
`timescale 1ns/1ps
module cam_match
  import cam_filt_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned ADDR_W    = 48
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             prom_i,
  input  logic                             allmc_i,
  input  logic                             bcast_i,
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] entries_i,
  input  logic [N_ENTRIES-1:0]             mask_i,
  output logic                             valid_o,
  output logic                             accept_o,
  output logic [1:0]                       type_o
);
  logic [N_ENTRIES-1:0] hit_vec;
  logic s1_v, s1_hit, s1_grp, s1_ones, s1_prom, s1_allmc, s1_bcast;
  logic        acc_q;
  frame_type_e typ_q;
  logic        acc_d;
  frame_type_e typ_d;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = mask_i[g] && (entries_i[g] == addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_hit <= 1'b0; s1_grp <= 1'b0; s1_ones <= 1'b0;
      s1_prom <= 1'b0; s1_allmc <= 1'b0; s1_bcast <= 1'b0;
    end else begin
      s1_v     <= start_i;
      s1_hit   <= |hit_vec;
      s1_grp   <= addr_i[0];
      s1_ones  <= &addr_i;
      s1_prom  <= prom_i;
      s1_allmc <= allmc_i;
      s1_bcast <= bcast_i;
    end
  end

  // fixed priority: promiscuous, all-multicast, broadcast, CAM
  always_comb begin
    acc_d = 1'b0;
    typ_d = FT_PLAIN;
    if (s1_prom && !s1_grp)       acc_d = 1'b1;
    else if (s1_allmc && s1_grp) begin acc_d = 1'b1; typ_d = FT_MCAST; end
    else if (s1_bcast && s1_ones) begin acc_d = 1'b1; typ_d = FT_BCAST; end
    else if (s1_hit)              acc_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      acc_q   <= 1'b0;
      typ_q   <= FT_PLAIN;
    end else begin
      valid_o <= s1_v;
      acc_q   <= acc_d;
      typ_q   <= typ_d;
    end
  end

  assign accept_o = acc_q;
  assign type_o   = typ_q;

  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 valid_o); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i, 2)); // R8
  AST_REJECT_IS_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !accept_o) |-> (type_o == FT_PLAIN)); // R4
endmodule

// File: rtl/cam_addr_filter.sv
`timescale 1ns/1ps
module cam_addr_filter
  import cam_filt_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned CNT_W     = 5,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
  localparam int unsigned ADDR_W   = 3 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_mode_i,
  input  logic              prom_i,
  input  logic              allmc_i,
  input  logic              bcast_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic              start_i,
  output logic              valid_o,
  output logic              accept_o,
  output logic [1:0]        type_o,
  input  logic              load_start_i,
  input  logic [CNT_W-1:0]  load_count_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              load_busy_o,
  output logic              load_done_o,
  input  logic [1:0]        port_sel_i,
  input  logic [IDX_W-1:0]  port_ptr_i,
  output logic [WORD_W-1:0] port_data_o
);
  logic                             ent_we;
  logic [IDX_W-1:0]                 ent_idx;
  logic [ADDR_W-1:0]                ent_data;
  logic                             mask_we;
  logic [N_ENTRIES-1:0]             mask_data;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] entries;
  logic [N_ENTRIES-1:0]             mask;

  cam_load_seq #(.N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_load (
    .clk_i, .rst_ni,
    .start_i      (load_start_i),
    .count_i      (load_count_i),
    .word_valid_i,
    .word_data_i,
    .word_ready_o,
    .busy_o       (load_busy_o),
    .done_o       (load_done_o),
    .ent_we_o     (ent_we),
    .ent_idx_o    (ent_idx),
    .ent_data_o   (ent_data),
    .mask_we_o    (mask_we),
    .mask_data_o  (mask_data)
  );

  cam_store #(.N_ENTRIES(N_ENTRIES), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .ent_we_i    (ent_we),
    .ent_idx_i   (ent_idx),
    .ent_data_i  (ent_data),
    .mask_we_i   (mask_we),
    .mask_data_i (mask_data),
    .entries_o   (entries),
    .mask_o      (mask),
    .rd_en_i     (reset_mode_i),
    .rd_ptr_i    (port_ptr_i),
    .rd_sel_i    (port_sel_i),
    .rd_data_o   (port_data_o)
  );

  cam_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .clk_i, .rst_ni,
    .start_i,
    .addr_i    (dst_addr_i),
    .prom_i,
    .allmc_i,
    .bcast_i,
    .entries_i (entries),
    .mask_i    (mask),
    .valid_o,
    .accept_o,
    .type_o
  );

  AST_READBACK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_mode_i |-> (port_data_o == '0)); // R7
endmodule

// File: tb/tb_cam_addr_filter.sv
`timescale 1ns/1ps
module tb_cam_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_mode = 1'b0, prom = 1'b0, allmc = 1'b0, bcast = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        start = 1'b0;
  logic        valid_o, accept_o;
  logic [1:0]  type_o;
  logic        load_start = 1'b0;
  logic [4:0]  load_count = '0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_ready, load_busy, load_done;
  logic [1:0]  port_sel = '0;
  logic [3:0]  port_ptr = '0;
  logic [15:0] port_data;

  int checks = 0, fails = 0;
  int unsigned cyc = 0;
  bit finished = 0;

  typedef struct { logic acc; logic [1:0] ty; int unsigned at; string req; } exp_t;
  exp_t q[$];
  logic [47:0] m_cam [16];
  logic [15:0] m_mask = '0;

  cam_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .reset_mode_i(reset_mode),
    .prom_i(prom), .allmc_i(allmc), .bcast_i(bcast),
    .dst_addr_i(dst_addr), .start_i(start),
    .valid_o, .accept_o, .type_o,
    .load_start_i(load_start), .load_count_i(load_count),
    .word_valid_i(word_valid), .word_data_i(word_data),
    .word_ready_o(word_ready), .load_busy_o(load_busy), .load_done_o(load_done),
    .port_sel_i(port_sel), .port_ptr_i(port_ptr), .port_data_o(port_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] model(logic [47:0] a, bit p, bit m, bit b);
    bit hit = 0;
    for (int i = 0; i < 16; i++) if (m_mask[i] && m_cam[i] == a) hit = 1;
    if (p && !a[0]) return 3'b100;
    if (m && a[0])  return 3'b101;
    if (b && &a)    return 3'b110;
    if (hit)        return 3'b100;
    return 3'b000;
  endfunction

  // driver: one strobe per call, caller lowers start with idle()
  task automatic filt(logic [47:0] a, bit p, bit m, bit b, string req);
    logic [2:0] r;
    exp_t e;
    @(negedge clk);
    dst_addr = a; prom = p; allmc = m; bcast = b; start = 1'b1;
    r = model(a, p, m, b);
    e.acc = r[2]; e.ty = r[1:0]; e.at = cyc + 2; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) chk(0, "R8", "valid without request", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.at, "R8", "result cycle", 64'(cyc), 64'(e.at));
        chk(accept_o == e.acc, e.req, "accept", 64'(accept_o), 64'(e.acc));
        chk(type_o == e.ty, e.req, "type", 64'(type_o), 64'(e.ty));
      end
    end
  end

  task automatic send_word(logic [15:0] w);
    @(negedge clk);
    while (!word_ready) @(negedge clk);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic load_begin(int n);
    @(negedge clk);
    load_start = 1'b1; load_count = 5'(n);
    @(negedge clk);
    load_start = 1'b0;
    chk(load_busy && word_ready, "R6", "busy/ready after start", {load_busy, word_ready}, 2'b11);
    chk(!load_done, "R6", "done cleared by start", 64'(load_done), 0);
  endtask

  task automatic load_entry(int idx, logic [47:0] a);
    send_word(16'hBEEF);
    send_word(a[15:0]);
    send_word(a[31:16]);
    send_word(a[47:32]);
    m_cam[idx] = a;
  endtask

  task automatic load_mask(logic [15:0] m);
    send_word(m);
    m_mask = m;
    chk(!load_busy && load_done && !word_ready, "R6", "busy/done/ready after mask",
        {load_busy, load_done, word_ready}, 3'b010);
  endtask

  task automatic rd_chk(bit mode, int ptr, int sel, logic [15:0] exp, string req);
    @(negedge clk);
    reset_mode = mode; port_ptr = 4'(ptr); port_sel = 2'(sel);
    #1;
    chk(port_data == exp, req, $sformatf("readback ptr=%0d sel=%0d", ptr, sel), 64'(port_data), 64'(exp));
  endtask

  localparam logic [47:0] E0 = 48'h0A0B_0C0D_0E02;
  localparam logic [47:0] E1 = 48'h1112_1314_1516;
  localparam logic [47:0] E2 = 48'h2122_2324_2520;

  initial begin
    for (int i = 0; i < 16; i++) m_cam[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid_o && !load_busy && !load_done && !word_ready, "R6", "reset state",
        {valid_o, load_busy, load_done, word_ready}, 0);
    rd_chk(1, 0, 0, 16'h0000, "R9");

    // R9: zero address would hit entry 0 if the mask were not cleared
    filt(48'h0, 0, 0, 0, "R9"); idle();

    // R5/R6: load three entries, enable 0 and 2
    load_begin(3);
    load_entry(0, E0); load_entry(1, E1); load_entry(2, E2);
    load_mask(16'h0005);

    // R7 readback
    rd_chk(1, 0, 0, E0[15:0], "R7");
    rd_chk(1, 0, 1, E0[31:16], "R7");
    rd_chk(1, 0, 2, E0[47:32], "R7");
    rd_chk(1, 0, 3, 16'h0000, "R7");
    rd_chk(1, 2, 2, E2[47:32], "R5");
    rd_chk(1, 1, 0, E1[15:0], "R5");
    rd_chk(1, 3, 0, 16'h0000, "R5");
    rd_chk(0, 0, 0, 16'h0000, "R7");

    // R4 CAM, back-to-back strobes (R8)
    filt(E0, 0, 0, 0, "R4");
    filt(E1, 0, 0, 0, "R4");
    filt(E2, 0, 0, 0, "R4");
    filt(48'h6655_4433_2210, 0, 0, 0, "R4");
    idle();

    // R1-R3 priority
    filt(48'h0000_0000_0001, 0, 1, 0, "R2");
    filt(48'hFFFF_FFFF_FFFF, 0, 0, 1, "R3");
    filt(48'hFFFF_FFFF_FFFF, 0, 1, 1, "R2");
    filt(48'hFFFF_FFFF_FFFF, 0, 0, 0, "R3");
    filt(48'h7777_7777_7700, 1, 0, 0, "R1");
    filt(48'h7777_7777_7701, 1, 0, 0, "R1");
    filt(48'h7777_7777_7701, 1, 1, 1, "R2");
    filt(48'h0000_0000_0001, 0, 0, 1, "R3");
    idle();

    // R6: count 0 loads only the mask
    load_begin(0);
    load_mask(16'h0002);
    rd_chk(1, 0, 0, E0[15:0], "R6");
    filt(E0, 0, 0, 0, "R6");
    filt(E1, 0, 0, 0, "R6");
    idle();

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R8", "outstanding results", 64'(q.size()), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule